// File: doc/BRIEF.md
# Tagged Receive Queue for a Serial Port

This block is the receive-side character queue of a serial port. Each incoming character is stored with its own error tag (parity, framing, break). The tag leaves the queue only when that character reaches the head, and is then merged into the sticky line-status byte. Software therefore sees an error flag in the same read window as the character that caused it, not when the character arrived.

The block accepts characters from an external receive shifter. It hands the head character to the receive-buffer read port and keeps the data-ready, overrun and queue-error bits of the status byte. It honours a receive-flush command and raises a level-reached output against a selectable threshold.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY`: no entries.
- `OCC_PARTIAL`: between one and DEPTH-1 entries.
- `OCC_FULL`: DEPTH entries.

Its named transitions are:
- FILL: EMPTY to PARTIAL, on an accepted push.
- TOP_OFF: PARTIAL to FULL, when the last free slot is taken.
- RELEASE: FULL to PARTIAL, on a pop.
- DRAIN: PARTIAL to EMPTY, when the last entry is popped.
- FLUSH: any state to EMPTY, on `rx_flush`.

The default depth is 16. DEPTH must be at least 14 so that every trigger level can be reached.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset the queue is empty, `rbr_data` is 0x00, `trig_hit` is low and status bits 0 to 4 and 7 are all zero.
- R2: A pushed character keeps its low 5+`wlen_sel` bits and has the higher bits forced to zero. Characters are delivered in arrival order, and `rbr_data` shows the head character from the cycle after its push.
- R3: A pulse on `rbr_rd` removes the head entry. A pulse on `rbr_rd` while the queue is empty changes nothing, and `rbr_data` reads 0x00 whenever the queue is empty.
- R4: Data ready (status bit 0) is set by every push, stored or rejected. It clears when the last entry is popped.
- R5: A push while the queue holds DEPTH entries is not stored, even if a pop happens in the same cycle. It sets overrun (bit 1) and queue error (bit 7), and the stored entries stay intact.
- R6: The `rx_err` tag is stored with its character: bit 0 is parity, bit 1 is framing, bit 2 is break. The tag is ORed into status bits 2, 3 and 4 respectively, and it also sets bit 7. This happens one cycle after that entry becomes the head. Tags of entries behind the head never appear in the status byte.
- R7: A pulse on `lsr_rd` clears status bits 1 to 4 and 7; a set event in the same cycle wins. A merged tag is removed from its entry, so it does not reappear after the clear.
- R8: `rx_flush` empties the queue and clears data ready. It takes priority over a push or pop in the same cycle, and it leaves the error bits unchanged.
- R9: Status bits 5 and 6 follow `thr_empty` and `tx_empty`. With both high, an idle queue reads 0x60. A single character with a framing error reads 0xE9 once merged.
- R10: `tmo_restart` is high for exactly the one cycle after each push that is not flushed, whether the push was stored or rejected.
- R11: `trig_hit` is high while the entry count is at least 1, 4, 8 or 14, for `trig_sel` values 0, 1, 2 and 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Character from the shifter is valid this cycle |
| rx_char | input | 8 | Received character bits |
| rx_err | input | 3 | Error tag of the character: [0] parity, [1] framing, [2] break |
| wlen_sel | input | 2 | Word length select, length = 5 + value |
| rbr_rd | input | 1 | Receive-buffer read strobe (pops head) |
| lsr_rd | input | 1 | Status read strobe (clears error bits) |
| rx_flush | input | 1 | Receive flush command |
| trig_sel | input | 2 | Trigger threshold select |
| thr_empty | input | 1 | Transmit holding empty, shown as status bit 5 |
| tx_empty | input | 1 | Transmitter idle, shown as status bit 6 |
| rbr_data | output | 8 | Head character, 0x00 when empty |
| lsr_val | output | 8 | Line status byte |
| trig_hit | output | 1 | Entry count reached the selected threshold |
| tmo_restart | output | 1 | One-cycle pulse after each push, to restart the timeout count |

## Verification
The queue is exercised with several input patterns:
- Clean characters at every word length. These separate correct masking from truncation at the wrong bit.
- A single tagged character. This shows the one-cycle delay between data ready and the merged error bits.
- A clean character followed by a tagged one. This separates head-time reporting from arrival-time reporting, and shows that a cleared tag stays cleared.
- A fill to capacity plus one extra push. This exposes storage of a rejected character, a missing overrun, and every threshold boundary at each fill level.
- A flush driven together with a push. This shows whether flush priority holds.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } err_tag_t;

    typedef struct packed {
        err_tag_t   tag;
        logic [7:0] data;
    } rx_entry_t;

    function automatic int trig_level(input logic [1:0] sel);
        unique case (sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] wlen_mask(input logic [1:0] sel);
        return 8'hFF >> (2'd3 - sel);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_ptr,
    input  rx_entry_t     wr_entry,
    input  logic [AW-1:0] rd_ptr,
    input  logic          tag_clr,
    output rx_entry_t     rd_entry
);

    rx_entry_t slots [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            // A tag is cleared only at a non-empty head; a write lands on a
            // free slot, so both never target the same slot together.
            if (wr_en) begin
                slots[wr_ptr] <= wr_entry;
            end
            if (tag_clr) begin
                slots[rd_ptr].tag <= '0;
            end
        end
    end

    assign rd_entry = slots[rd_ptr];

endmodule

// File: rtl/rxq_occ_fsm.sv
module rxq_occ_fsm
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          flush,
    output logic          wr_en,
    output logic          pop_en,
    output logic          reject,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output occ_state_t    state
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    occ_state_t    state_q, state_d;
    logic [CW-1:0] count_q;
    logic [AW-1:0] wptr_q, rptr_q;

    // outputs of the occupancy machine
    always_comb begin
        wr_en  = push_req && !flush && (state_q != OCC_FULL);
        pop_en = pop_req  && !flush && (state_q != OCC_EMPTY);
        reject = push_req && !flush && (state_q == OCC_FULL);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;                                   // FLUSH
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (wr_en) state_d = OCC_PARTIAL;              // FILL
                end
                OCC_PARTIAL: begin
                    if (wr_en && !pop_en && count_q == FULL_CNT - 1'b1)
                        state_d = OCC_FULL;                        // TOP_OFF
                    else if (pop_en && !wr_en && count_q == CW'(1))
                        state_d = OCC_EMPTY;                       // DRAIN
                end
                OCC_FULL: begin
                    if (pop_en) state_d = OCC_PARTIAL;             // RELEASE
                end
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // pointers and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else if (flush) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            count_q <= count_q + CW'(wr_en) - CW'(pop_en);
            if (wr_en)  wptr_q <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
            if (pop_en) rptr_q <= (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
        end
    end

    assign wr_ptr = wptr_q;
    assign rd_ptr = rptr_q;
    assign count  = count_q;
    assign state  = state_q;

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_seen,
    input  logic     reject,
    input  logic     flush,
    input  logic     last_pop,
    input  err_tag_t merge_tag,
    input  logic     lsr_rd,
    output logic     dr,
    output logic     oe,
    output logic     pe,
    output logic     fe,
    output logic     bi,
    output logic     qerr,
    output logic     tmo_pulse
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr        <= 1'b0;
            oe        <= 1'b0;
            pe        <= 1'b0;
            fe        <= 1'b0;
            bi        <= 1'b0;
            qerr      <= 1'b0;
            tmo_pulse <= 1'b0;
        end else begin
            if (flush)          dr <= 1'b0;
            else if (push_seen) dr <= 1'b1;
            else if (last_pop)  dr <= 1'b0;

            if (reject)         oe <= 1'b1;
            else if (lsr_rd)    oe <= 1'b0;

            if (merge_tag.par)  pe <= 1'b1;
            else if (lsr_rd)    pe <= 1'b0;

            if (merge_tag.frm)  fe <= 1'b1;
            else if (lsr_rd)    fe <= 1'b0;

            if (merge_tag.brk)  bi <= 1'b1;
            else if (lsr_rd)    bi <= 1'b0;

            if (reject || (|merge_tag)) qerr <= 1'b1;
            else if (lsr_rd)            qerr <= 1'b0;

            tmo_pulse <= push_seen;
        end
    end

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    input  logic [2:0] rx_err,
    input  logic [1:0] wlen_sel,
    input  logic       rbr_rd,
    input  logic       lsr_rd,
    input  logic       rx_flush,
    input  logic [1:0] trig_sel,
    input  logic       thr_empty,
    input  logic       tx_empty,
    output logic [7:0] rbr_data,
    output logic [7:0] lsr_val,
    output logic       trig_hit,
    output logic       tmo_restart
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, pop_en, reject;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ_count;
    occ_state_t    occ_state;
    rx_entry_t     new_entry, head_entry;
    err_tag_t      merge_tag;
    logic          tag_clr, last_pop, push_seen;
    logic          st_dr, st_oe, st_pe, st_fe, st_bi, st_qerr;

    always_comb begin
        new_entry.data = rx_char & wlen_mask(wlen_sel);
        new_entry.tag  = err_tag_t'(rx_err);
    end

    rxq_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (rx_push),
        .pop_req  (rbr_rd),
        .flush    (rx_flush),
        .wr_en    (wr_en),
        .pop_en   (pop_en),
        .reject   (reject),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (occ_count),
        .state    (occ_state)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_entry (new_entry),
        .rd_ptr   (rd_ptr),
        .tag_clr  (tag_clr),
        .rd_entry (head_entry)
    );

    // head-tag merge and event decode
    always_comb begin
        merge_tag = (occ_state != OCC_EMPTY) ? head_entry.tag : '0;
        tag_clr   = |merge_tag;
        push_seen = rx_push && !rx_flush;
        last_pop  = pop_en && !wr_en && (occ_count == CW'(1));
    end

    rxq_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_seen (push_seen),
        .reject    (reject),
        .flush     (rx_flush),
        .last_pop  (last_pop),
        .merge_tag (merge_tag),
        .lsr_rd    (lsr_rd),
        .dr        (st_dr),
        .oe        (st_oe),
        .pe        (st_pe),
        .fe        (st_fe),
        .bi        (st_bi),
        .qerr      (st_qerr),
        .tmo_pulse (tmo_restart)
    );

    // block outputs
    always_comb begin
        rbr_data = (occ_state != OCC_EMPTY) ? head_entry.data : 8'h00;
        lsr_val  = {st_qerr, tx_empty, thr_empty, st_bi, st_fe, st_pe, st_oe, st_dr};
        trig_hit = int'(occ_count) >= trig_level(trig_sel);
    end

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_push,
    input logic          rx_flush,
    input logic          lsr_rd,
    input logic [1:0]    trig_sel,
    input logic [CW-1:0] occ_count,
    input logic [7:0]    rbr_data,
    input logic [7:0]    lsr_val,
    input logic          trig_hit,
    input logic          tmo_restart
);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_count) <= DEPTH);

    // R5
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush && int'(occ_count) == DEPTH) |=> (lsr_val[1] && lsr_val[7]));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (occ_count == '0 && !lsr_val[0]));

    // R4
    dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush) |=> lsr_val[0]);

    // R10
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_flush) |=> tmo_restart);

    // R3
    empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_count == '0) |-> (rbr_data == 8'h00));

    // R11
    level_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == 2'd0) |-> (trig_hit == (occ_count != '0)));

    // R7
    lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_push && occ_count == '0) |=> (lsr_val[4:1] == 4'h0 && !lsr_val[7]));

endmodule

bind rxq_tagged_fifo rxq_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_push     (rx_push),
    .rx_flush    (rx_flush),
    .lsr_rd      (lsr_rd),
    .trig_sel    (trig_sel),
    .occ_count   (occ_count),
    .rbr_data    (rbr_data),
    .lsr_val     (lsr_val),
    .trig_hit    (trig_hit),
    .tmo_restart (tmo_restart)
);

// File: tb/rxq_tagged_fifo_tb.sv
`timescale 1ns/1ps
module rxq_tagged_fifo_tb;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic [2:0] rx_err = 3'b000;
    logic [1:0] wlen_sel = 2'd3;
    logic       rbr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       rx_flush = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       thr_empty = 1'b1;
    logic       tx_empty = 1'b1;
    logic [7:0] rbr_data;
    logic [7:0] lsr_val;
    logic       trig_hit;
    logic       tmo_restart;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rxq_tagged_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_push     (rx_push),
        .rx_char     (rx_char),
        .rx_err      (rx_err),
        .wlen_sel    (wlen_sel),
        .rbr_rd      (rbr_rd),
        .lsr_rd      (lsr_rd),
        .rx_flush    (rx_flush),
        .trig_sel    (trig_sel),
        .thr_empty   (thr_empty),
        .tx_empty    (tx_empty),
        .rbr_data    (rbr_data),
        .lsr_val     (lsr_val),
        .trig_hit    (trig_hit),
        .tmo_restart (tmo_restart)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%02h exp=0x%02h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        rx_push = 1'b1; rx_char = d; rx_err = e;
        @(negedge clk);
        rx_push = 1'b0; rx_err = 3'b000;
    endtask

    task automatic pop();
        @(negedge clk);
        rbr_rd = 1'b1;
        @(negedge clk);
        rbr_rd = 1'b0;
    endtask

    task automatic read_lsr();
        @(negedge clk);
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset lsr", lsr_val, 8'h60);
        chk("R1 reset rbr", rbr_data, 8'h00);
        chk("R1 reset trig", {7'd0, trig_hit}, 8'h00);
    endtask

    task automatic t_mask_order();
        for (int w = 0; w < 4; w++) begin
            wlen_sel = w[1:0];
            push(8'hFF, 3'b000);
            chk("R2 mask", rbr_data, 8'hFF >> (3 - w));
            pop();
        end
        wlen_sel = 2'd3;
        push(8'hA1, 3'b000);
        push(8'hB2, 3'b000);
        push(8'hC3, 3'b000);
        chk("R2 order head", rbr_data, 8'hA1);
        pop();
        chk("R3 pop next", rbr_data, 8'hB2);
        pop();
        chk("R3 pop last", rbr_data, 8'hC3);
        pop();
        chk("R4 dr cleared", lsr_val, 8'h60);
        pop();
        chk("R3 empty pop", rbr_data, 8'h00);
        push(8'h5A, 3'b000);
        chk("R3 after empty pop", rbr_data, 8'h5A);
        chk("R10 restart pulse", {7'd0, tmo_restart}, 8'h01);
        idle(1);
        chk("R10 pulse ends", {7'd0, tmo_restart}, 8'h00);
        pop();
    endtask

    task automatic t_frame();
        push(8'h41, 3'b010);
        chk("R6 tag not yet merged", lsr_val, 8'h61);
        idle(1);
        chk("R9 framing lsr", lsr_val, 8'hE9);
        pop();
        chk("R4 dr clears, errors stay", lsr_val, 8'hE8);
        read_lsr();
        chk("R7 lsr read clears", lsr_val, 8'h60);
    endtask

    task automatic t_tag_order();
        push(8'h11, 3'b000);
        push(8'h22, 3'b001);
        idle(2);
        chk("R6 tag behind head hidden", lsr_val, 8'h61);
        pop();
        idle(1);
        chk("R6 parity at head", lsr_val, 8'hE5);
        chk("R6 head data", rbr_data, 8'h22);
        read_lsr();
        idle(2);
        chk("R7 tag not re-merged", lsr_val, 8'h61);
        pop();
        chk("R4 empty again", lsr_val, 8'h60);
    endtask

    task automatic t_fill_overrun();
        int lv [4] = '{1, 4, 8, 14};
        for (int k = 0; k <= DEPTH; k++) begin
            for (int s = 0; s < 4; s++) begin
                trig_sel = s[1:0];
                #0.1;
                chk("R11 trigger", {7'd0, trig_hit}, {7'd0, k >= lv[s]});
            end
            if (k < DEPTH) push(8'(k * 7 + 3), 3'b000);
        end
        trig_sel = 2'd0;
        push(8'hEE, 3'b000);
        chk("R5 overrun lsr", lsr_val, 8'hE3);
        chk("R10 pulse on reject", {7'd0, tmo_restart}, 8'h01);
        read_lsr();
        chk("R7 overrun cleared", lsr_val, 8'h61);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R5 kept entries", rbr_data, 8'(k * 7 + 3));
            pop();
        end
        chk("R5 rejected not stored", rbr_data, 8'h00);
        chk("R4 dr after drain", lsr_val, 8'h60);
    endtask

    task automatic t_flush();
        push(8'h01, 3'b000);
        push(8'h02, 3'b000);
        push(8'h03, 3'b000);
        @(negedge clk);
        rx_flush = 1'b1; rx_push = 1'b1; rx_char = 8'h77;
        @(negedge clk);
        rx_flush = 1'b0; rx_push = 1'b0;
        chk("R8 flush dr", lsr_val, 8'h60);
        chk("R8 flush rbr", rbr_data, 8'h00);
        chk("R8 flush trig", {7'd0, trig_hit}, 8'h00);
        push(8'h33, 3'b000);
        chk("R8 push after flush", rbr_data, 8'h33);
        pop();
    endtask

    task automatic t_tx_bits();
        thr_empty = 1'b0; tx_empty = 1'b0;
        #0.1;
        chk("R9 tx bits low", lsr_val, 8'h00);
        thr_empty = 1'b1;
        #0.1;
        chk("R9 thr bit", lsr_val, 8'h20);
        tx_empty = 1'b1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_mask_order();
        t_frame();
        t_tag_order();
        t_fill_overrun();
        t_flush();
        t_tx_bits();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule